// File: doc/BRIEF.md
# Serial EEPROM Slave with Four-Wire Synchronous Bus

This block is the digital front end of a small non-volatile memory of 128 words of 16 bits, reached over a four-wire serial bus: a select line, a serial clock, a data input and a data output. Each access is a frame. The frame begins with a 1 start bit, then a two-bit opcode, then an eight-bit address field. Read returns a word. Write, erase, erase-all and write-all change the contents. Two opcode-qualified commands turn modification on and off. The storage is a register file, and every line is sampled in one system clock domain.

A modifying command is launched when the select line falls after a complete frame. The word is committed at once, and the block then stays busy for a programmable number of system clock cycles. If select is raised during that time, the data output shows the status: 0 while busy, 1 once ready. Dropping select clears the frame logic at any time, so a partial frame is thrown away.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After `rst` the block is write-disabled, every word reads 0xFFFF, and `sdo_oe` is 0 while `sel` is low.
- R2: `sdo_oe` is 1 one cycle after `sel` is sampled high and 0 one cycle after `sel` is sampled low.
- R3: A frame with opcode 10 followed by 8 address bits sends a 0 dummy bit on `sdo` after the rise of `sclk` that clocks in the last address bit. The addressed word follows MSB first, one bit per later rising edge of `sclk`.
- R4: Opcode 01 with 16 data bits, MSB first, overwrites the addressed word when `sel` falls. No erase is needed first.
- R5: Opcode 11 sets every bit of the addressed word to 1.
- R6: Opcode 00 with the top two address bits at 11 enables modification, and with 00 disables it. While modification is disabled, write, erase, erase-all and write-all leave the array unchanged.
- R7: Opcode 00 with qualifier 10 sets all words to 0xFFFF. With qualifier 01 followed by 16 data bits, it writes that value to all words.
- R8: A launched command keeps the block busy for exactly PROG_CYCLES system clock cycles. With `sel` high, `sdo` is 0 while busy and 1 after the cycle completes, until the next start bit.
- R9: Lowering `sel` in the middle of a frame discards it, and the next frame is decoded from scratch.
- R10: Zeros that come before the start bit are ignored. The top bit of the 8-bit address field is ignored.
- R11: While busy, no start bit is accepted, so a frame sent during the program cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip select, active high; low clears the frame logic |
| sclk | input | 1 | Serial clock; inputs are taken on its rising edge |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out: read data or busy/ready status |
| sdo_oe | output | 1 | Output enable for the data-out pad |

## Verification
A corrupted phase or bit counter moves the read window. It shows up in the dummy bit or the first data bit of the next read, within 17 serial clocks. A wrong enable flag or a wrong launch condition stays hidden until the word is read back, so each modifying command is followed by a read of the words it could have changed. A program timer with the wrong length is seen on the status bit a few cycles either side of the expected end of busy.

// File: rtl/ee_pkg.sv
package ee_pkg;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_READ, CMD_WRITE, CMD_ERASE,
        CMD_ERAL, CMD_WRAL, CMD_WEN, CMD_WDIS
    } cmd_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_HDR, PH_DATA, PH_RDOUT, PH_WAIT
    } phase_e;

    function automatic cmd_e decode_cmd(input logic [1:0] opc, input logic [1:0] qual);
        cmd_e c;
        case (opc)
            2'b10:   c = CMD_READ;
            2'b01:   c = CMD_WRITE;
            2'b11:   c = CMD_ERASE;
            default: begin
                case (qual)
                    2'b11:   c = CMD_WEN;
                    2'b00:   c = CMD_WDIS;
                    2'b10:   c = CMD_ERAL;
                    default: c = CMD_WRAL;
                endcase
            end
        endcase
        return c;
    endfunction

    function automatic logic is_prog(input cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_ERAL) || (c == CMD_WRAL);
    endfunction

    function automatic logic needs_data(input cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_WRAL);
    endfunction

    function automatic logic is_erase(input cmd_e c);
        return (c == CMD_ERASE) || (c == CMD_ERAL);
    endfunction

endpackage

// File: rtl/ee_prog_timer.sv
module ee_prog_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (start)         cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/ee_array.sv
module ee_array #(
    parameter int AW = 7,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          all,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int w = 0; w < DEPTH; w++) begin
            if (rst)
                mem[w] <= '1;
            else if (we && (all || wr_addr == AW'(w)))
                mem[w] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import ee_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe
);
    localparam int HDR_W = ADDR_W + 3;
    localparam int MAXB  = (DATA_W > HDR_W) ? DATA_W : HDR_W;
    localparam int CW    = $clog2(MAXB + 1);

    logic              sclk_q, sel_q, sdo_oe_q;
    phase_e            phase_q;
    logic [CW-1:0]     cnt_q;
    logic [HDR_W-1:0]  hdr_q, hdr_next;
    cmd_e              cmd_q, dec;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] dat_q, rd_data, arr_data;
    logic [DATA_W:0]   shreg_q;
    logic              wen_q, stat_q;
    logic              rise, launch, arr_we, arr_all, prog_busy;

    assign rise     = sclk & ~sclk_q & sel;
    assign hdr_next = {hdr_q[HDR_W-2:0], sdi};
    assign dec      = decode_cmd(hdr_next[HDR_W-1 -: 2], hdr_next[ADDR_W -: 2]);

    assign launch   = sel_q & ~sel & (phase_q == PH_WAIT) & is_prog(cmd_q) & wen_q & ~prog_busy;
    assign arr_we   = launch;
    assign arr_all  = (cmd_q == CMD_ERAL) || (cmd_q == CMD_WRAL);
    assign arr_data = is_erase(cmd_q) ? '1 : dat_q;

    ee_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .we      (arr_we),
        .all     (arr_all),
        .wr_addr (addr_q),
        .wr_data (arr_data),
        .rd_addr (hdr_next[ADDR_W-1:0]),
        .rd_data (rd_data)
    );

    ee_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (launch),
        .busy  (prog_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            sel_q    <= 1'b0;
            sdo_oe_q <= 1'b0;
            phase_q  <= PH_IDLE;
            cnt_q    <= '0;
            hdr_q    <= '0;
            cmd_q    <= CMD_NONE;
            addr_q   <= '0;
            dat_q    <= '0;
            shreg_q  <= '0;
            wen_q    <= 1'b0;
            stat_q   <= 1'b0;
        end else begin
            sclk_q   <= sclk;
            sel_q    <= sel;
            sdo_oe_q <= sel;
            if (launch) stat_q <= 1'b1;
            if (!sel) begin
                phase_q <= PH_IDLE;
                cnt_q   <= '0;
                hdr_q   <= '0;
                cmd_q   <= CMD_NONE;
                dat_q   <= '0;
                shreg_q <= '0;
            end else if (rise) begin
                case (phase_q)
                    PH_IDLE: begin
                        if (sdi && !prog_busy) begin
                            phase_q <= PH_HDR;
                            cnt_q   <= '0;
                            stat_q  <= 1'b0;
                        end
                    end
                    PH_HDR: begin
                        hdr_q <= hdr_next;
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CW'(HDR_W - 1)) begin
                            cmd_q  <= dec;
                            addr_q <= hdr_next[ADDR_W-1:0];
                            cnt_q  <= '0;
                            phase_q <= PH_WAIT;
                            if (dec == CMD_READ) begin
                                shreg_q <= {1'b0, rd_data};
                                phase_q <= PH_RDOUT;
                            end else if (needs_data(dec)) begin
                                phase_q <= PH_DATA;
                            end else if (dec == CMD_WEN) begin
                                wen_q <= 1'b1;
                            end else if (dec == CMD_WDIS) begin
                                wen_q <= 1'b0;
                            end
                        end
                    end
                    PH_DATA: begin
                        dat_q <= {dat_q[DATA_W-2:0], sdi};
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CW'(DATA_W - 1)) phase_q <= PH_WAIT;
                    end
                    PH_RDOUT: shreg_q <= {shreg_q[DATA_W-1:0], 1'b0};
                    default: ;
                endcase
            end
        end
    end

    assign sdo    = sel & (stat_q ? ~prog_busy : ((phase_q == PH_RDOUT) & shreg_q[DATA_W]));
    assign sdo_oe = sdo_oe_q;
endmodule

// File: rtl/ee_chk.sv
module ee_chk (
    input logic clk,
    input logic rst,
    input logic sel,
    input logic sdo,
    input logic sdo_oe,
    input logic busy,
    input logic stat,
    input logic arr_we,
    input logic wen
);
    AST_OE_RISES: assert property (@(posedge clk) disable iff (rst) sel |=> sdo_oe);             // R2
    AST_OE_FALLS: assert property (@(posedge clk) disable iff (rst) !sel |=> !sdo_oe);           // R2
    AST_PROG_NEEDS_WEN: assert property (@(posedge clk) disable iff (rst) arr_we |-> wen);        // R6
    AST_LAUNCH_STARTS_BUSY: assert property (@(posedge clk) disable iff (rst) arr_we |=> busy);   // R8
    AST_STATUS_LOW_BUSY: assert property (@(posedge clk) disable iff (rst) (sel && stat && busy) |-> !sdo); // R8
    AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (rst) busy |-> !arr_we);      // R11
endmodule

bind serial_eeprom_slave ee_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel),
    .sdo    (sdo),
    .sdo_oe (sdo_oe),
    .busy   (prog_busy),
    .stat   (stat_q),
    .arr_we (arr_we),
    .wen    (wen_q)
);

// File: tb/serial_eeprom_slave_tb.sv
module serial_eeprom_slave_tb;
    localparam int PROG = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo, sdo_oe;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic [15:0] exp_q[$];
    logic [15:0] got_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    serial_eeprom_slave #(.ADDR_W(7), .DATA_W(16), .PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst(rst), .sel(sel), .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic sbit(input logic b, output logic o);
        @(negedge clk) sdi = b;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (3) @(negedge clk);
        o = sdo;
        sclk = 1'b0;
    endtask

    task automatic frame(input logic [1:0] opc, input logic [7:0] a8, input bit wdat,
                         input logic [15:0] d, input int pre, output logic last);
        logic o;
        sel = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < pre; i++) sbit(1'b0, o);
        sbit(1'b1, o);
        sbit(opc[1], o);
        sbit(opc[0], o);
        for (int i = 7; i >= 0; i--) sbit(a8[i], o);
        last = o;
        if (wdat) for (int i = 15; i >= 0; i--) sbit(d[i], o);
    endtask

    task automatic cmd(input logic [1:0] opc, input logic [7:0] a8, input bit wdat,
                       input logic [15:0] d, input int pre);
        logic o;
        frame(opc, a8, wdat, d, pre, o);
        sel = 1'b0;
        repeat (PROG + 10) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a8, input logic [15:0] exp, input string tag);
        logic o;
        logic [15:0] g;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        frame(2'b10, a8, 1'b0, 16'h0, 0, o);
        check("R3 dummy bit", {15'h0, o}, 16'h0);
        for (int i = 15; i >= 0; i--) begin
            sbit(1'b0, o);
            g[i] = o;
        end
        sel = 1'b0;
        repeat (3) @(negedge clk);
        got_q.push_back(g);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (got_q.size() > 0) begin
                logic [15:0] g, e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, g, e);
            end
        end
    end

    initial begin
        logic o;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 oe low at reset", {15'h0, sdo_oe}, 16'h0);
        rd(8'h00, 16'hFFFF, "R1 erased after reset");
        sel = 1'b1; repeat (2) @(negedge clk);
        check("R2 oe follows sel high", {15'h0, sdo_oe}, 16'h1);
        sel = 1'b0; repeat (2) @(negedge clk);
        check("R2 oe follows sel low", {15'h0, sdo_oe}, 16'h0);

        cmd(2'b01, 8'h05, 1'b1, 16'hA5C3, 0);
        rd(8'h05, 16'hFFFF, "R6 write ignored while disabled");

        cmd(2'b00, 8'hC0, 1'b0, 16'h0, 0);
        frame(2'b01, 8'h05, 1'b1, 16'hA5C3, 0, o);
        sel = 1'b0;
        repeat (2) @(negedge clk);
        sel = 1'b1;
        repeat (288) @(negedge clk);
        check("R8 status busy before end", {15'h0, sdo}, 16'h0);
        repeat (15) @(negedge clk);
        check("R8 status ready after end", {15'h0, sdo}, 16'h1);
        sel = 1'b0;
        repeat (5) @(negedge clk);
        rd(8'h05, 16'hA5C3, "R4 write when enabled");
        cmd(2'b01, 8'h05, 1'b1, 16'h1234, 0);
        rd(8'h05, 16'h1234, "R4 overwrite without erase");
        cmd(2'b11, 8'h05, 1'b0, 16'h0, 0);
        rd(8'h05, 16'hFFFF, "R5 erase word");

        cmd(2'b01, 8'hFF, 1'b1, 16'h0F0F, 3);
        rd(8'h7F, 16'h0F0F, "R10 leading zeros and top address bit");

        frame(2'b01, 8'h03, 1'b0, 16'h0, 0, o);
        for (int i = 0; i < 6; i++) sbit(1'b0, o);
        sel = 1'b0;
        repeat (PROG + 10) @(negedge clk);
        rd(8'h03, 16'hFFFF, "R9 aborted frame");

        frame(2'b01, 8'h04, 1'b1, 16'h4444, 0, o);
        sel = 1'b0;
        repeat (2) @(negedge clk);
        frame(2'b01, 8'h09, 1'b1, 16'h0000, 0, o);
        sel = 1'b0;
        repeat (PROG + 10) @(negedge clk);
        rd(8'h09, 16'hFFFF, "R11 frame during busy ignored");
        rd(8'h04, 16'h4444, "R11 launched write kept");

        cmd(2'b00, 8'h80, 1'b0, 16'h0, 0);
        rd(8'h04, 16'hFFFF, "R7 erase-all word 4");
        rd(8'h7F, 16'hFFFF, "R7 erase-all word 127");
        cmd(2'b00, 8'h40, 1'b1, 16'h5A5A, 0);
        rd(8'h00, 16'h5A5A, "R7 write-all word 0");
        rd(8'h4D, 16'h5A5A, "R7 write-all word 77");
        rd(8'h7F, 16'h5A5A, "R7 write-all word 127");

        cmd(2'b00, 8'h00, 1'b0, 16'h0, 0);
        cmd(2'b01, 8'h02, 1'b1, 16'h0000, 0);
        rd(8'h02, 16'h5A5A, "R6 write ignored after disable");
        cmd(2'b11, 8'h02, 1'b0, 16'h0, 0);
        rd(8'h02, 16'h5A5A, "R6 erase ignored after disable");

        repeat (5) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule